// File: doc/BRIEF.md
# Buffered I2C Master Transaction Sequencer

This block runs whole I2C master transactions on top of a byte-level bus engine. The host first loads payload bytes into a small transfer buffer and then posts one write or read request. The block builds the rest of the buffer itself: the address byte and, for a write, the register-address bytes. It then asks the engine for a START condition.

From then on the transfer is steered only by the 8-bit status codes that the engine returns after each bus event. For every code the block updates a packed status byte and answers with exactly one command. The command is one of: send the next buffer byte, receive a byte and return ACK, receive a byte and return NACK, or generate STOP.

A watchdog counter guards every transaction. If it expires, the block flags a timeout and tells the engine to return to its idle state. To read a device register, the host issues a write that carries only the register address, followed by a separate read request. Received bytes are read back through a registered index port.

Top module: `i2c_txn_seq`

## Requirements
- R1: After synchronous reset the status byte is 0x00 and eng_cmd_valid, req_ack and req_rej are all 0.
- R2: A request sampled while a transaction is running is refused with a one-cycle req_rej pulse. A request sampled while idle with the timeout bit set is also refused, and that refusal clears the timeout bit. An idle request is likewise refused when its register-address length is 3, or when its total byte count exceeds DEPTH. The total is 1+alen+plen for a write and 1+plen for a read. Otherwise the request gets a one-cycle req_ack pulse and the status byte becomes 0x80.
- R3: Buffer position 0 receives the chip address shifted left by one, with bit 0 set to 1 for a read. For a write, positions 1 and 2 take the register address, low byte first, for as many bytes as alen gives. A payload write presents pl_idx and takes effect while idle at position 1+req_alen+pl_idx. Payload writes made during a transaction are ignored.
- R4: Commands are coded 0 START, 1 SEND, 2 RECV-ACK, 3 RECV-NACK, 4 STOP, 5 RESET. Each command is a one-cycle eng_cmd_valid pulse.
- R5: START (code 0) is issued once the buffer is set up. A status event sampled at a clock edge is answered at that same edge, and only the upper five bits of the code are compared. Code 0x08 or 0x10 sets the status to 0x88 and sends buffer byte 0.
- R6: Code 0x18 sets bit 2 and code 0x28 sets bit 1. If bytes remain, the next byte is sent. Otherwise bit 0 is set, bit 7 is cleared and STOP is issued.
- R7: Code 0x30 sets bit 0, clears bit 7 and issues STOP.
- R8: After code 0x40 (which sets bit 2), or after code 0x50 (which sets bit 1 and stores the received byte), RECV-ACK is requested while the next index is below plen. Otherwise RECV-NACK is requested.
- R9: Code 0x58 stores the received byte, sets bits 2, 1 and 0, clears bit 7 and issues STOP.
- R10: Every other code clears bit 7 and issues STOP without setting bit 0. Examples are 0x20, 0x48, 0x38 and 0x00.
- R11: If a transaction has run TMO_CYCLES cycles since it was accepted, bit 7 is cleared, bit 6 is set and RESET is issued.
- R12: Status events that arrive while no transaction is waiting for one are ignored.
- R13: rd_data shows buffer position 1+rd_idx one cycle after rd_idx is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_read | input | 1 | 1 = read transaction, 0 = write |
| req_chip | input | 7 | 7-bit device address |
| req_reg | input | 16 | Register address, low byte sent first |
| req_alen | input | 2 | Register address bytes (0..2); also sets the payload write offset |
| req_plen | input | LW | Payload byte count |
| req_ack | output | 1 | Request accepted |
| req_rej | output | 1 | Request refused |
| pl_we | input | 1 | Payload byte write strobe |
| pl_idx | input | AW | Payload byte index |
| pl_data | input | 8 | Payload byte |
| rd_idx | input | AW | Received-byte index |
| rd_data | output | 8 | Buffer byte at 1+rd_idx |
| stat | output | 8 | Packed status: 7 busy, 6 timeout, 3 START, 2 address ACK, 1 data ACK, 0 done |
| eng_cmd_valid | output | 1 | Command strobe to the engine |
| eng_cmd | output | 3 | Command code |
| eng_txd | output | 8 | Byte to send with SEND |
| eng_stat_valid | input | 1 | Status event strobe from the engine |
| eng_stat | input | 8 | Engine status code |
| eng_rxd | input | 8 | Received byte |

## Verification
The bench builds the block with DEPTH = 8 and TMO_CYCLES = 200. With a buffer of eight bytes, both the largest accepted transfer and the first refused transfer fit in a few requests. With a 200-cycle watchdog, a stalled transfer expires within the run, and the refusal that clears the timeout can then be exercised. The engine side is played by scripted status codes, some with non-zero low bits. These cover writes with zero and two register bytes, a data NACK, reads of one and three bytes, an address NACK, lost arbitration and events while idle.

// File: rtl/i2c_txn_pkg.sv
package i2c_txn_pkg;

  typedef enum logic [2:0] {
    CMD_START   = 3'd0,
    CMD_SEND    = 3'd1,
    CMD_RX_ACK  = 3'd2,
    CMD_RX_NACK = 3'd3,
    CMD_STOP    = 3'd4,
    CMD_RESET   = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_WAIT  = 2'd2
  } phase_e;

  localparam logic [7:0] CODE_MASK     = 8'hF8;
  localparam logic [7:0] EV_START      = 8'h08;
  localparam logic [7:0] EV_RSTART     = 8'h10;
  localparam logic [7:0] EV_WADR_ACK   = 8'h18;
  localparam logic [7:0] EV_WDAT_ACK   = 8'h28;
  localparam logic [7:0] EV_WDAT_NACK  = 8'h30;
  localparam logic [7:0] EV_RADR_ACK   = 8'h40;
  localparam logic [7:0] EV_RDAT_ACK   = 8'h50;
  localparam logic [7:0] EV_RDAT_NACK  = 8'h58;

  localparam int SB_BUSY = 7;
  localparam int SB_TMO  = 6;
  localparam int SB_STA  = 3;
  localparam int SB_ADR  = 2;
  localparam int SB_DAT  = 1;
  localparam int SB_DONE = 0;

endpackage

// File: rtl/i2c_txn_buf.sv
module i2c_txn_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic          re_a,
  input  logic [AW-1:0] ra_a,
  output logic [7:0]    qa,
  input  logic [AW-1:0] ra_b,
  output logic [7:0]    qb
);

  logic [7:0] mem [DEPTH];

  // read-first RAM: one write port, two registered read ports
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re_a) qa <= mem[ra_a];
    qb <= mem[ra_b];
  end

endmodule

// File: rtl/i2c_txn_tmo.sv
module i2c_txn_tmo #(
  parameter int TMO_CYCLES = 3000000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic fire
);

  localparam int CW = $clog2(TMO_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end

  assign fire = run && (cnt == CW'(TMO_CYCLES - 1));

endmodule

// File: rtl/i2c_txn_react.sv
module i2c_txn_react
  import i2c_txn_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic [7:0]    code,
  input  logic [LW-1:0] idx,
  input  logic [LW-1:0] len,
  input  logic [7:0]    st_in,
  output logic [7:0]    st_out,
  output cmd_e          cmd,
  output logic [LW-1:0] idx_out,
  output logic          send,
  output logic [LW-1:0] send_pos,
  output logic          store,
  output logic          finish
);

  logic [7:0]    c;
  logic [LW-1:0] idx_inc;
  logic [LW-1:0] last_ack;

  assign c        = code & CODE_MASK;
  assign idx_inc  = idx + LW'(1);
  assign last_ack = len - LW'(1);

  always_comb begin
    st_out   = st_in;
    cmd      = CMD_STOP;
    idx_out  = idx;
    send     = 1'b0;
    send_pos = idx;
    store    = 1'b0;
    finish   = 1'b0;
    case (c)
      EV_START, EV_RSTART: begin
        st_out   = 8'h88;
        send     = 1'b1;
        send_pos = '0;
        idx_out  = LW'(1);
        cmd      = CMD_SEND;
      end
      EV_WADR_ACK, EV_WDAT_ACK: begin
        if (c == EV_WADR_ACK) st_out[SB_ADR] = 1'b1;
        else                  st_out[SB_DAT] = 1'b1;
        if (idx < len) begin
          send    = 1'b1;
          idx_out = idx_inc;
          cmd     = CMD_SEND;
        end else begin
          st_out[SB_DONE] = 1'b1;
          st_out[SB_BUSY] = 1'b0;
          finish          = 1'b1;
        end
      end
      EV_WDAT_NACK: begin
        st_out[SB_DONE] = 1'b1;
        st_out[SB_BUSY] = 1'b0;
        finish          = 1'b1;
      end
      EV_RADR_ACK: begin
        st_out[SB_ADR] = 1'b1;
        cmd = (idx < last_ack) ? CMD_RX_ACK : CMD_RX_NACK;
      end
      EV_RDAT_ACK: begin
        st_out[SB_DAT] = 1'b1;
        store   = 1'b1;
        idx_out = idx_inc;
        cmd = (idx_inc < last_ack) ? CMD_RX_ACK : CMD_RX_NACK;
      end
      EV_RDAT_NACK: begin
        st_out[SB_ADR]  = 1'b1;
        st_out[SB_DAT]  = 1'b1;
        st_out[SB_DONE] = 1'b1;
        st_out[SB_BUSY] = 1'b0;
        store   = 1'b1;
        idx_out = idx_inc;
        finish  = 1'b1;
      end
      default: begin
        st_out[SB_BUSY] = 1'b0;
        finish          = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2c_txn_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int TMO_CYCLES = 3000000,
  parameter int AW         = $clog2(DEPTH),
  parameter int LW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_read,
  input  logic [6:0]    req_chip,
  input  logic [15:0]   req_reg,
  input  logic [1:0]    req_alen,
  input  logic [LW-1:0] req_plen,
  output logic          req_ack,
  output logic          req_rej,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_idx,
  input  logic [7:0]    pl_data,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic [7:0]    stat,
  output logic          eng_cmd_valid,
  output logic [2:0]    eng_cmd,
  output logic [7:0]    eng_txd,
  input  logic          eng_stat_valid,
  input  logic [7:0]    eng_stat,
  input  logic [7:0]    eng_rxd
);

  localparam int TW = LW + 2;

  phase_e        phase;
  logic [7:0]    stat_q;
  logic [LW-1:0] idx_q, len_q;
  logic          rd_q;
  logic [6:0]    chip_q;
  logic [15:0]   reg_q;
  logic [1:0]    alen_q, pos_q, last_pos;

  logic [TW-1:0] tot_w, tot_r, tot;
  logic          req_ok;

  logic [7:0]    r_st;
  cmd_e          r_cmd;
  logic [LW-1:0] r_idx, r_send_pos;
  logic          r_send, r_store, r_finish;

  logic          tmo_fire;
  logic          ev_take;

  logic          m_we, m_re;
  logic [AW-1:0] m_wa, m_ra;
  logic [7:0]    m_wd;

  assign tot_w    = TW'(req_plen) + TW'(req_alen) + TW'(1);
  assign tot_r    = TW'(req_plen) + TW'(1);
  assign tot      = req_read ? tot_r : tot_w;
  assign req_ok   = (req_alen != 2'd3) && (tot <= TW'(DEPTH));
  assign last_pos = rd_q ? 2'd0 : alen_q;
  assign ev_take  = (phase == PH_WAIT) && eng_stat_valid && !tmo_fire;

  i2c_txn_react #(.LW(LW)) u_react (
    .code     (eng_stat),
    .idx      (idx_q),
    .len      (len_q),
    .st_in    (stat_q),
    .st_out   (r_st),
    .cmd      (r_cmd),
    .idx_out  (r_idx),
    .send     (r_send),
    .send_pos (r_send_pos),
    .store    (r_store),
    .finish   (r_finish)
  );

  i2c_txn_tmo #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
    .clk  (clk),
    .rst  (rst),
    .run  (phase != PH_IDLE),
    .fire (tmo_fire)
  );

  // single write port: host payload while idle, setup bytes, received bytes
  always_comb begin
    m_we = 1'b0;
    m_wa = pl_idx + AW'(req_alen) + AW'(1);
    m_wd = pl_data;
    case (phase)
      PH_IDLE: m_we = pl_we;
      PH_SETUP: begin
        m_we = 1'b1;
        m_wa = AW'(pos_q);
        case (pos_q)
          2'd0:    m_wd = {chip_q, rd_q};
          2'd1:    m_wd = reg_q[7:0];
          default: m_wd = reg_q[15:8];
        endcase
      end
      default: begin
        m_we = ev_take && r_store && (idx_q < LW'(DEPTH));
        m_wa = AW'(idx_q);
        m_wd = eng_rxd;
      end
    endcase
  end

  assign m_re = ev_take && r_send;
  assign m_ra = AW'(r_send_pos);

  i2c_txn_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk  (clk),
    .we   (m_we),
    .wa   (m_wa),
    .wd   (m_wd),
    .re_a (m_re),
    .ra_a (m_ra),
    .qa   (eng_txd),
    .ra_b (rd_idx + AW'(1)),
    .qb   (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase         <= PH_IDLE;
      stat_q        <= '0;
      idx_q         <= '0;
      len_q         <= '0;
      rd_q          <= 1'b0;
      chip_q        <= '0;
      reg_q         <= '0;
      alen_q        <= '0;
      pos_q         <= '0;
      req_ack       <= 1'b0;
      req_rej       <= 1'b0;
      eng_cmd_valid <= 1'b0;
      eng_cmd       <= CMD_STOP;
    end else begin
      req_ack       <= 1'b0;
      req_rej       <= req_valid && (phase != PH_IDLE);
      eng_cmd_valid <= 1'b0;
      if (tmo_fire) begin
        stat_q[SB_BUSY] <= 1'b0;
        stat_q[SB_TMO]  <= 1'b1;
        eng_cmd_valid   <= 1'b1;
        eng_cmd         <= CMD_RESET;
        phase           <= PH_IDLE;
      end else begin
        case (phase)
          PH_IDLE: begin
            if (req_valid) begin
              if (stat_q[SB_TMO]) begin
                req_rej        <= 1'b1;
                stat_q[SB_TMO] <= 1'b0;
              end else if (req_ok) begin
                req_ack <= 1'b1;
                stat_q  <= 8'h80;
                phase   <= PH_SETUP;
                rd_q    <= req_read;
                chip_q  <= req_chip;
                reg_q   <= req_reg;
                alen_q  <= req_alen;
                len_q   <= LW'(tot);
                idx_q   <= '0;
                pos_q   <= '0;
              end else begin
                req_rej <= 1'b1;
              end
            end
          end
          PH_SETUP: begin
            if (pos_q == last_pos) begin
              eng_cmd_valid <= 1'b1;
              eng_cmd       <= CMD_START;
              phase         <= PH_WAIT;
            end else begin
              pos_q <= pos_q + 2'd1;
            end
          end
          default: begin
            if (eng_stat_valid) begin
              stat_q        <= r_st;
              idx_q         <= r_idx;
              eng_cmd_valid <= 1'b1;
              eng_cmd       <= r_cmd;
              if (r_finish) phase <= PH_IDLE;
            end
          end
        endcase
      end
    end
  end

  assign stat = stat_q;

endmodule

// File: rtl/i2c_txn_seq_chk.sv
module i2c_txn_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] stat,
  input logic       eng_cmd_valid,
  input logic [2:0] eng_cmd,
  input logic       req_ack,
  input logic       req_rej
);

  // R2: an accepted request always starts from a non-busy, timeout-free state
  p_accept_state_r2: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> (stat == 8'h80) && $past(stat[7:6] == 2'b00));

  // R2: accept and refuse never coincide
  p_ack_rej_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(req_ack && req_rej));

  // R5: START goes out while the status is still plain busy
  p_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (eng_cmd_valid && eng_cmd == 3'd0) |-> (stat == 8'h80));

  // R10: a STOP always leaves busy clear
  p_stop_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (eng_cmd_valid && eng_cmd == 3'd4) |-> !stat[7]);

  // R11: RESET command comes with timeout set and busy clear
  p_reset_flags_r11: assert property (@(posedge clk) disable iff (rst)
    (eng_cmd_valid && eng_cmd == 3'd5) |-> (stat[6] && !stat[7]));

  // R6: done is never reported together with busy
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    stat[0] |-> !stat[7]);

endmodule

bind i2c_txn_seq i2c_txn_seq_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .stat          (stat),
  .eng_cmd_valid (eng_cmd_valid),
  .eng_cmd       (eng_cmd),
  .req_ack       (req_ack),
  .req_rej       (req_rej)
);

// File: tb/i2c_txn_seq_test.sv
module i2c_txn_seq_test;

  localparam int D  = 8;
  localparam int T  = 200;
  localparam int AW = $clog2(D);
  localparam int LW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 0, req_read = 0;
  logic [6:0]    req_chip = 0;
  logic [15:0]   req_reg = 0;
  logic [1:0]    req_alen = 0;
  logic [LW-1:0] req_plen = 0;
  logic          req_ack, req_rej;
  logic          pl_we = 0;
  logic [AW-1:0] pl_idx = 0, rd_idx = 0;
  logic [7:0]    pl_data = 0, rd_data, stat, eng_txd;
  logic          eng_cmd_valid;
  logic [2:0]    eng_cmd;
  logic          eng_stat_valid = 0;
  logic [7:0]    eng_stat = 0, eng_rxd = 0;

  always #5 clk = ~clk;

  i2c_txn_seq #(.DEPTH(D), .TMO_CYCLES(T)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_read(req_read),
    .req_chip(req_chip), .req_reg(req_reg), .req_alen(req_alen),
    .req_plen(req_plen), .req_ack(req_ack), .req_rej(req_rej),
    .pl_we(pl_we), .pl_idx(pl_idx), .pl_data(pl_data), .rd_idx(rd_idx),
    .rd_data(rd_data), .stat(stat), .eng_cmd_valid(eng_cmd_valid),
    .eng_cmd(eng_cmd), .eng_txd(eng_txd), .eng_stat_valid(eng_stat_valid),
    .eng_stat(eng_stat), .eng_rxd(eng_rxd)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_buf [D];
  bit         m_bv  [D];
  int  m_ph, m_old, m_pos, m_last, m_idx, m_len, m_tc, m_tot, m_code;
  bit  m_rd, m_ack, m_rej, m_cmdv, m_rdv;
  logic [7:0] m_st, m_txd, m_rdq, m_chip8;
  logic [15:0] m_reg;
  int  m_cmd;

  function automatic void wbuf(input int a, input logic [7:0] v);
    m_buf[a % D] = v;
    m_bv[a % D]  = 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_st = 0; m_ack = 0; m_rej = 0; m_cmdv = 0; m_tc = 0;
      m_rdv = 0; m_idx = 0; m_len = 0;
      for (int i = 0; i < D; i++) m_bv[i] = 0;
    end else begin
      m_old = m_ph;
      m_ack = 0; m_rej = 0; m_cmdv = 0;
      m_rdv = m_bv[(rd_idx + 1) % D];
      m_rdq = m_buf[(rd_idx + 1) % D];
      if (req_valid && m_ph != 0) m_rej = 1;
      if (m_ph != 0 && m_tc == T - 1) begin
        m_st = (m_st & 8'h3F) | 8'h40; m_cmdv = 1; m_cmd = 5; m_ph = 0;
      end else if (m_ph == 0) begin
        if (pl_we) wbuf(1 + req_alen + pl_idx, pl_data);
        if (req_valid) begin
          m_tot = req_read ? req_plen + 1 : 1 + req_alen + req_plen;
          if (m_st[6]) begin m_rej = 1; m_st[6] = 0; end
          else if (req_alen == 3 || m_tot > D) m_rej = 1;
          else begin
            m_ack = 1; m_st = 8'h80; m_ph = 1; m_pos = 0; m_idx = 0;
            m_len = m_tot; m_rd = req_read; m_reg = req_reg;
            m_chip8 = {req_chip, req_read};
            m_last = req_read ? 0 : req_alen;
          end
        end
      end else if (m_ph == 1) begin
        wbuf(m_pos, m_pos == 0 ? m_chip8 : (m_pos == 1 ? m_reg[7:0] : m_reg[15:8]));
        if (m_pos == m_last) begin m_cmdv = 1; m_cmd = 0; m_ph = 2; end
        else m_pos++;
      end else if (eng_stat_valid) begin
        m_code = eng_stat & 8'hF8;
        m_cmdv = 1;
        m_cmd  = 4;
        case (m_code)
          8'h08, 8'h10: begin m_st = 8'h88; m_txd = m_buf[0]; m_idx = 1; m_cmd = 1; end
          8'h18, 8'h28: begin
            m_st = m_st | (m_code == 8'h18 ? 8'h04 : 8'h02);
            if (m_idx < m_len) begin m_txd = m_buf[m_idx]; m_idx++; m_cmd = 1; end
            else begin m_st = (m_st | 8'h01) & 8'h7F; m_ph = 0; end
          end
          8'h30: begin m_st = (m_st | 8'h01) & 8'h7F; m_ph = 0; end
          8'h40: begin m_st = m_st | 8'h04; m_cmd = (m_idx < m_len - 1) ? 2 : 3; end
          8'h50: begin
            m_st = m_st | 8'h02; wbuf(m_idx, eng_rxd); m_idx++;
            m_cmd = (m_idx < m_len - 1) ? 2 : 3;
          end
          8'h58: begin
            m_st = (m_st | 8'h07) & 8'h7F; wbuf(m_idx, eng_rxd); m_idx++; m_ph = 0;
          end
          default: begin m_st = m_st & 8'h7F; m_ph = 0; end
        endcase
      end
      m_tc = (m_old != 0) ? m_tc + 1 : 0;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R6 stat vs model", stat, m_st);
      chk("R4 cmd_valid vs model", eng_cmd_valid, m_cmdv);
      if (m_cmdv) chk("R4 cmd vs model", eng_cmd, m_cmd);
      if (m_cmdv && m_cmd == 1) chk("R3 txd vs model", eng_txd, m_txd);
      chk("R2 ack vs model", req_ack, m_ack);
      chk("R2 rej vs model", req_rej, m_rej);
      if (m_rdv) chk("R13 rd_data vs model", rd_data, m_rdq);
    end
  end

  // ---------------- stimulus helpers ----------------
  logic       got_v, got_ack, got_rej, got_start;
  logic [2:0] got_cmd;
  logic [7:0] got_txd;

  task automatic ev(input logic [7:0] code, input logic [7:0] rx);
    @(negedge clk);
    eng_stat_valid = 1; eng_stat = code; eng_rxd = rx;
    @(negedge clk);
    eng_stat_valid = 0;
    got_v = eng_cmd_valid; got_cmd = eng_cmd; got_txd = eng_txd;
  endtask

  task automatic load(input logic [1:0] al, input int k, input logic [7:0] v);
    @(negedge clk);
    req_alen = al; pl_we = 1; pl_idx = AW'(k); pl_data = v;
    @(negedge clk);
    pl_we = 0;
  endtask

  task automatic req(input bit rd, input logic [6:0] chip, input logic [15:0] rg,
                     input logic [1:0] al, input int pl);
    @(negedge clk);
    req_read = rd; req_chip = chip; req_reg = rg; req_alen = al;
    req_plen = LW'(pl); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    got_ack = req_ack; got_rej = req_rej; got_start = 0;
    if (got_ack)
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (eng_cmd_valid && eng_cmd == 3'd0) got_start = 1;
      end
  endtask

  task automatic expect_cmd(input string tag, input logic [2:0] c);
    chk(tag, {got_v, got_cmd}, {1'b1, c});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 stat during reset", stat, 8'h00);
    rst = 0;
    @(negedge clk);
    chk("R1 stat after reset", stat, 8'h00);
    chk("R1 no command", eng_cmd_valid, 1'b0);
    chk("R1 no ack/rej", {req_ack, req_rej}, 2'b00);

    // write, two register bytes, two payload bytes
    load(2'd2, 0, 8'h11);
    load(2'd2, 1, 8'h22);
    req(0, 7'h52, 16'hBEEF, 2'd2, 2);
    chk("R2 write accepted", {got_ack, got_rej}, 2'b10);
    chk("R5 START issued", got_start, 1'b1);
    ev(8'h0B, 0);  // low bits must be ignored
    expect_cmd("R5 send after START", 3'd1);
    chk("R3 byte0 chip+W", got_txd, 8'hA4);
    chk("R5 status after START", stat, 8'h88);
    ev(8'h1A, 0);
    expect_cmd("R6 send after addr ACK", 3'd1);
    chk("R3 reg low byte first", got_txd, 8'hEF);
    load(2'd2, 0, 8'h99);  // ignored while busy
    ev(8'h28, 0);
    chk("R3 reg high byte", got_txd, 8'hBE);
    req(0, 7'h01, 16'h0, 2'd0, 0);
    chk("R2 busy request refused", {got_ack, got_rej}, 2'b01);
    ev(8'h28, 0);
    chk("R3 payload write while busy ignored", got_txd, 8'h11);
    ev(8'h28, 0);
    chk("R3 payload byte 1", got_txd, 8'h22);
    ev(8'h28, 0);
    expect_cmd("R6 STOP when bytes used up", 3'd4);
    chk("R6 final write status", stat, 8'h0F);
    ev(8'h28, 0);
    chk("R12 idle event ignored", got_v, 1'b0);
    chk("R12 idle status unchanged", stat, 8'h0F);

    // write, no register bytes, data NACK, repeated START code
    load(2'd0, 0, 8'h5A);
    req(0, 7'h3C, 16'h0, 2'd0, 1);
    ev(8'h10, 0);
    chk("R5 repeated START sends byte0", got_txd, 8'h78);
    ev(8'h18, 0);
    chk("R6 payload after addr ACK", got_txd, 8'h5A);
    ev(8'h30, 0);
    expect_cmd("R7 STOP on data NACK", 3'd4);
    chk("R7 NACK status", stat, 8'h0D);

    // read of three bytes
    req(1, 7'h50, 16'h0, 2'd0, 3);
    ev(8'h08, 0);
    chk("R3 byte0 chip+R", got_txd, 8'hA1);
    ev(8'h40, 0);
    expect_cmd("R8 ACK after addr+R", 3'd2);
    ev(8'h50, 8'hC1);
    expect_cmd("R8 ACK second byte", 3'd2);
    ev(8'h50, 8'hC2);
    expect_cmd("R8 NACK last byte", 3'd3);
    ev(8'h58, 8'hC3);
    expect_cmd("R9 STOP after NACKed byte", 3'd4);
    chk("R9 read status", stat, 8'h0F);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rd_idx = AW'(i);
      @(negedge clk);
      chk("R13 readback", rd_data, 8'hC1 + 8'(i));
    end

    // one-byte read: NACK at once
    req(1, 7'h50, 16'h0, 2'd0, 1);
    ev(8'h08, 0);
    ev(8'h40, 0);
    expect_cmd("R8 single byte NACK", 3'd3);
    ev(8'h58, 8'h3E);
    chk("R9 single byte status", stat, 8'h0F);
    @(negedge clk); rd_idx = 0;
    @(negedge clk);
    chk("R13 single byte readback", rd_data, 8'h3E);

    // address NACK and lost arbitration
    req(0, 7'h10, 16'h0, 2'd0, 0);
    ev(8'h08, 0);
    ev(8'h20, 0);
    expect_cmd("R10 STOP on addr NACK", 3'd4);
    chk("R10 addr NACK status", stat, 8'h08);
    req(1, 7'h10, 16'h0, 2'd0, 2);
    ev(8'h08, 0);
    ev(8'h38, 0);
    expect_cmd("R10 STOP on arbitration lost", 3'd4);
    chk("R10 arbitration status", stat, 8'h08);

    // zero-length write completes on address ACK
    req(0, 7'h10, 16'h0, 2'd0, 0);
    ev(8'h08, 0);
    ev(8'h18, 0);
    chk("R6 empty write done", stat, 8'h0D);

    // parameter refusals
    req(0, 7'h10, 16'h0, 2'd3, 0);
    chk("R2 alen 3 refused", {got_ack, got_rej}, 2'b01);
    req(0, 7'h10, 16'h0, 2'd2, 6);
    chk("R2 nine bytes refused", {got_ack, got_rej}, 2'b01);
    req(1, 7'h10, 16'h0, 2'd0, 8);
    chk("R2 long read refused", {got_ack, got_rej}, 2'b01);
    chk("R2 refusal keeps status", stat, 8'h0D);

    // largest write accepted, then stalled into timeout
    req(0, 7'h10, 16'h1234, 2'd2, 5);
    chk("R2 eight bytes accepted", {got_ack, got_rej}, 2'b10);
    ev(8'h08, 0);
    got_v = 0;
    for (int i = 0; i < 300 && !got_v; i++) begin
      @(negedge clk);
      if (eng_cmd_valid && eng_cmd == 3'd5) got_v = 1;
    end
    chk("R11 RESET issued", got_v, 1'b1);
    chk("R11 timeout status", stat, 8'h48);
    req(0, 7'h10, 16'h0, 2'd0, 0);
    chk("R2 refused after timeout", {got_ack, got_rej}, 2'b01);
    chk("R2 timeout bit cleared", stat, 8'h08);
    req(0, 7'h10, 16'h0, 2'd0, 0);
    chk("R2 accepted once cleared", {got_ack, got_rej}, 2'b10);
    ev(8'h08, 0);
    ev(8'h18, 0);
    chk("R6 transfer after timeout", stat, 8'h0D);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule